// File: doc/BRIEF.md
# DDR Burst Column Sequencer

This block turns one DDR SDRAM column command into the column addresses of its data beats and the timing of those beats. Because data moves on both clock edges, the block gives two column addresses per clock: `*_col0` for the even beat and `*_col1` for the odd beat that follows it. A write burst appears on the write-beat outputs in the clock after the command. A read burst appears on the read-beat outputs after the programmed read latency.

A mode-load strobe carries a 7-bit mode word. The word sets the burst length (2, 4, 8 or the whole 256-column page), the beat order (sequential or interleaved) and the read latency (3 to 5 clocks). An illegal mode word raises a level error flag. A whole-page burst with an odd start column is refused and reported. A read that arrives while write beats are still flowing is also refused and reported. A burst-stop input ends any burst that is running. A new accepted command replaces the burst that is running.

Top module: `ddr_burst_seq`

## Requirements
- R1: Mode word layout: bits [2:0] give the length code (1 = two beats, 2 = four, 3 = eight, 7 = whole page), bit 3 selects interleaved order when 1, and bits [6:4] give the read latency. A legal word loaded by `mode_load` takes effect for the next command and clears `mode_err` in the following cycle.
- R2: A mode word with a length code outside {1,2,3,7} or a latency outside 3..5 sets `mode_err` in the next cycle and leaves the active settings unchanged.
- R3: A whole-page length with interleaved order is loaded as whole-page sequential, and `mode_err` is set in the next cycle.
- R4: In sequential order, beat b of a burst of length N at start column s is at column (s with its low log2(N) bits replaced by (s+b) mod N). Beat 2k is on `col0` and beat 2k+1 is on `col1` of the k-th beat pair.
- R5: In interleaved order, beat b is at column s XOR b.
- R6: An accepted write command raises `wr_vld` from the next cycle for N/2 consecutive cycles, with `rd_vld` low.
- R7: An accepted read command with latency L raises `rd_vld` from the L-th cycle after the command, for N/2 consecutive cycles, with `wr_vld` low.
- R8: A whole-page burst is sequential, wraps from column 255 to 0, and runs until `burst_stop` or a new accepted command.
- R9: In whole-page mode, a command with an odd start column is ignored and pulses `start_err` for one cycle in the next cycle.
- R10: A read command that arrives in a cycle with `wr_vld` high is ignored and pulses `rd_refused` for one cycle in the next cycle. The write burst continues.
- R11: `burst_stop` without an accepted command makes the running burst produce no beat pair after the current one. An accepted command during a burst starts the new burst in the next cycle.
- R12: After reset, all valid and error outputs are low and the settings are length 4, sequential, latency 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load the mode word this cycle |
| mode_word | input | 7 | Length code, order select and read latency |
| cmd_valid | input | 1 | Column command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | 8 | Start column |
| burst_stop | input | 1 | End the running burst |
| wr_vld | output | 1 | Write beat pair valid |
| wr_col0 | output | 8 | Column of the even write beat |
| wr_col1 | output | 8 | Column of the odd write beat |
| rd_vld | output | 1 | Read beat pair valid |
| rd_col0 | output | 8 | Column of the even read beat |
| rd_col1 | output | 8 | Column of the odd read beat |
| mode_err | output | 1 | Last mode word was illegal or was coerced |
| start_err | output | 1 | Odd whole-page start refused |
| rd_refused | output | 1 | Read during a write burst refused |

## Verification
The bench sends odd and high start columns through both orders and every length. A design that wraps outside the aligned block, or that swaps the XOR order with the additive order, shows a wrong column on one beat of the pair. Whole-page bursts start near column 255, so a missing wrap at the page edge shows up as a wrong column. Reads are run at each latency and are checked for the exact first cycle, which catches a latency tap that is off by one register. The bench also checks the refused cases (odd page start, read during a write, illegal mode word that must keep the old settings) and the stop and restart cases, where a design that keeps running or drops the new burst shows an extra or missing beat pair.

// File: rtl/ddrseq_pkg.sv
`timescale 1ns/1ps
package ddrseq_pkg;
  localparam int COL_W   = 8;
  localparam int PAIR_W  = COL_W - 1;
  localparam int LAT_W   = 3;
  localparam int MODE_W  = 7;
  localparam int MIN_LAT = 3;
  localparam int MAX_LAT = 5;

  localparam logic [2:0] LEN_CODE_2    = 3'd1;
  localparam logic [2:0] LEN_CODE_4    = 3'd2;
  localparam logic [2:0] LEN_CODE_8    = 3'd3;
  localparam logic [2:0] LEN_CODE_PAGE = 3'd7;

  typedef enum logic [1:0] {BL_2, BL_4, BL_8, BL_PAGE} blen_e;

  typedef struct packed {
    blen_e            blen;
    logic             ilv;
    logic [LAT_W-1:0] lat;
  } mode_t;

  // Mask of the column bits that wrap inside one burst block
  function automatic logic [COL_W-1:0] wrap_mask(blen_e b);
    case (b)
      BL_2:    return COL_W'(1);
      BL_4:    return COL_W'(3);
      BL_8:    return COL_W'(7);
      default: return '1;
    endcase
  endfunction

  // Number of beat pairs in a fixed-length burst
  function automatic logic [PAIR_W-1:0] pairs_of(blen_e b);
    case (b)
      BL_2:    return PAIR_W'(1);
      BL_4:    return PAIR_W'(2);
      BL_8:    return PAIR_W'(4);
      default: return '0;
    endcase
  endfunction

  // Column of beat number 'beat' of a burst starting at 'start'
  function automatic logic [COL_W-1:0] beat_col(logic [COL_W-1:0] start,
                                                logic [COL_W-1:0] beat,
                                                blen_e b, logic ilv);
    logic [COL_W-1:0] m;
    m = wrap_mask(b);
    if (ilv && b != BL_PAGE) return start ^ (beat & m);
    return (start & ~m) | ((start + beat) & m);
  endfunction
endpackage

// File: rtl/ddrseq_mode_reg.sv
`timescale 1ns/1ps
module ddrseq_mode_reg
  import ddrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode_q,
  output logic              err_q
);
  logic [2:0]       len_code;
  logic             ilv_req;
  logic [LAT_W-1:0] lat_req;
  logic             len_ok;
  logic             lat_ok;
  blen_e            blen_req;

  assign len_code = word[2:0];
  assign ilv_req  = word[3];
  assign lat_req  = word[6:4];
  assign lat_ok   = (lat_req >= LAT_W'(MIN_LAT)) && (lat_req <= LAT_W'(MAX_LAT));

  always_comb begin
    len_ok   = 1'b1;
    blen_req = BL_4;
    case (len_code)
      LEN_CODE_2:    blen_req = BL_2;
      LEN_CODE_4:    blen_req = BL_4;
      LEN_CODE_8:    blen_req = BL_8;
      LEN_CODE_PAGE: blen_req = BL_PAGE;
      default:       len_ok   = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{blen: BL_4, ilv: 1'b0, lat: LAT_W'(MIN_LAT)};
      err_q  <= 1'b0;
    end else if (load) begin
      if (!len_ok || !lat_ok) begin
        err_q <= 1'b1;
      end else begin
        mode_q.blen <= blen_req;
        mode_q.ilv  <= ilv_req && (blen_req != BL_PAGE);
        mode_q.lat  <= lat_req;
        err_q       <= ilv_req && (blen_req == BL_PAGE);
      end
    end
  end
endmodule

// File: rtl/ddrseq_addr_gen.sv
`timescale 1ns/1ps
module ddrseq_addr_gen
  import ddrseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  mode_t            mode,
  input  logic             stop,
  output logic             gen_vld,
  output logic             gen_wr,
  output logic [COL_W-1:0] gen_c0,
  output logic [COL_W-1:0] gen_c1
);
  logic              act_q;
  logic              wr_q;
  logic [COL_W-1:0]  col_q;
  blen_e             blen_q;
  logic              ilv_q;
  logic [PAIR_W-1:0] pair_q;
  logic              last_pair;

  assign last_pair = (blen_q != BL_PAGE) && (pair_q == pairs_of(blen_q) - PAIR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      col_q  <= '0;
      blen_q <= BL_4;
      ilv_q  <= 1'b0;
      pair_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      wr_q   <= start_wr;
      col_q  <= start_col;
      blen_q <= mode.blen;
      ilv_q  <= mode.ilv;
      pair_q <= '0;
    end else if (stop || (act_q && last_pair)) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      pair_q <= pair_q + PAIR_W'(1);
    end
  end

  assign gen_vld = act_q;
  assign gen_wr  = wr_q;
  assign gen_c0  = beat_col(col_q, {pair_q, 1'b0}, blen_q, ilv_q);
  assign gen_c1  = beat_col(col_q, {pair_q, 1'b1}, blen_q, ilv_q);
endmodule

// File: rtl/ddrseq_lat_pipe.sv
`timescale 1ns/1ps
module ddrseq_lat_pipe
  import ddrseq_pkg::*;
#(
  parameter int DEPTH = MAX_LAT - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [COL_W-1:0] in_c0,
  input  logic [COL_W-1:0] in_c1,
  input  logic [LAT_W-1:0] lat,
  output logic             out_vld,
  output logic [COL_W-1:0] out_c0,
  output logic [COL_W-1:0] out_c1
);
  logic [DEPTH-1:0] vld_sr;
  logic [COL_W-1:0] c0_sr [DEPTH];
  logic [COL_W-1:0] c1_sr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sr <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        c0_sr[i] <= '0;
        c1_sr[i] <= '0;
      end
    end else begin
      vld_sr[0] <= in_vld;
      c0_sr[0]  <= in_c0;
      c1_sr[0]  <= in_c1;
      for (int i = 1; i < DEPTH; i++) begin
        vld_sr[i] <= vld_sr[i-1];
        c0_sr[i]  <= c0_sr[i-1];
        c1_sr[i]  <= c1_sr[i-1];
      end
    end
  end

  // Stage i is visible i+2 cycles after the command edge
  always_comb begin
    out_vld = 1'b0;
    out_c0  = '0;
    out_c1  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lat == LAT_W'(i + 2)) begin
        out_vld = vld_sr[i];
        out_c0  = c0_sr[i];
        out_c1  = c1_sr[i];
      end
    end
  end
endmodule

// File: rtl/ddr_burst_seq.sv
`timescale 1ns/1ps
module ddr_burst_seq
  import ddrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              burst_stop,
  output logic              wr_vld,
  output logic [COL_W-1:0]  wr_col0,
  output logic [COL_W-1:0]  wr_col1,
  output logic              rd_vld,
  output logic [COL_W-1:0]  rd_col0,
  output logic [COL_W-1:0]  rd_col1,
  output logic              mode_err,
  output logic              start_err,
  output logic              rd_refused
);
  mode_t            mode_q;
  logic [LAT_W-1:0] lat_cur;
  logic             page_odd;
  logic             rd_blocked;
  logic             cmd_take;
  logic             rd_take;
  logic             stop_take;
  logic             gen_vld;
  logic             gen_wr;
  logic [COL_W-1:0] gen_c0;
  logic [COL_W-1:0] gen_c1;

  ddrseq_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (mode_load),
    .word   (mode_word),
    .mode_q (mode_q),
    .err_q  (mode_err)
  );

  assign lat_cur    = mode_q.lat;
  assign page_odd   = cmd_valid && (mode_q.blen == BL_PAGE) && cmd_col[0];
  assign rd_blocked = cmd_valid && !cmd_write && wr_vld;
  assign cmd_take   = cmd_valid && !page_odd && !rd_blocked;
  assign rd_take    = cmd_take && !cmd_write;
  assign stop_take  = burst_stop && !cmd_take;

  ddrseq_addr_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_take),
    .start_wr  (cmd_write),
    .start_col (cmd_col),
    .mode      (mode_q),
    .stop      (stop_take),
    .gen_vld   (gen_vld),
    .gen_wr    (gen_wr),
    .gen_c0    (gen_c0),
    .gen_c1    (gen_c1)
  );

  assign wr_vld  = gen_vld && gen_wr;
  assign wr_col0 = gen_c0;
  assign wr_col1 = gen_c1;

  ddrseq_lat_pipe #(.DEPTH(MAX_LAT - 1)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (gen_vld && !gen_wr),
    .in_c0   (gen_c0),
    .in_c1   (gen_c1),
    .lat     (lat_cur),
    .out_vld (rd_vld),
    .out_c0  (rd_col0),
    .out_c1  (rd_col1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_err  <= 1'b0;
      rd_refused <= 1'b0;
    end else begin
      start_err  <= page_odd;
      rd_refused <= rd_blocked;
    end
  end
endmodule

// File: rtl/ddrseq_chk.sv
`timescale 1ns/1ps
module ddrseq_chk
  import ddrseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_load,
  input logic [MODE_W-1:0] mode_word,
  input logic              cmd_take,
  input logic              cmd_write,
  input logic              stop_take,
  input logic              wr_vld,
  input logic [COL_W-1:0]  wr_col0,
  input logic [COL_W-1:0]  wr_col1,
  input logic              rd_vld,
  input logic [COL_W-1:0]  rd_col0,
  input logic [COL_W-1:0]  rd_col1,
  input logic              mode_err,
  input logic              rd_refused
);
  // R6
  wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take && cmd_write |=> wr_vld);

  // R2
  bad_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load && (mode_word[6:4] < 3'd3 || mode_word[6:4] > 3'd5) |=> mode_err);

  // R3
  page_ilv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load && mode_word[2:0] == 3'd7 && mode_word[3] |=> mode_err);

  // R11
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_take |=> !wr_vld);

  // R4
  wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> wr_col0[0] != wr_col1[0]);

  // R5
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> rd_col0[0] != rd_col1[0]);

  // R10
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_refused |-> $past(wr_vld));
endmodule

bind ddr_burst_seq ddrseq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_load  (mode_load),
  .mode_word  (mode_word),
  .cmd_take   (cmd_take),
  .cmd_write  (cmd_write),
  .stop_take  (stop_take),
  .wr_vld     (wr_vld),
  .wr_col0    (wr_col0),
  .wr_col1    (wr_col1),
  .rd_vld     (rd_vld),
  .rd_col0    (rd_col0),
  .rd_col1    (rd_col1),
  .mode_err   (mode_err),
  .rd_refused (rd_refused)
);

// File: tb/tb_ddr_burst_seq.sv
`timescale 1ns/1ps
module tb_ddr_burst_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_load;
  logic [6:0] mode_word;
  logic       cmd_valid;
  logic       cmd_write;
  logic [7:0] cmd_col;
  logic       burst_stop;
  logic       wr_vld, rd_vld, mode_err, start_err, rd_refused;
  logic [7:0] wr_col0, wr_col1, rd_col0, rd_col1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ddr_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .burst_stop(burst_stop), .wr_vld(wr_vld), .wr_col0(wr_col0), .wr_col1(wr_col1),
    .rd_vld(rd_vld), .rd_col0(rd_col0), .rd_col1(rd_col1), .mode_err(mode_err),
    .start_err(start_err), .rd_refused(rd_refused)
  );

  // Vector: [15] write, [14:12] length code, [11] interleave, [10:8] latency, [7:0] start
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 3'd2, 1'b0, 3'd3, 8'd5},
    {1'b0, 3'd3, 1'b1, 3'd4, 8'd3},
    {1'b0, 3'd1, 1'b0, 3'd5, 8'd9},
    {1'b1, 3'd3, 1'b0, 3'd3, 8'd13},
    {1'b1, 3'd2, 1'b1, 3'd4, 8'd14},
    {1'b0, 3'd7, 1'b0, 3'd3, 8'd252},
    {1'b1, 3'd7, 1'b0, 3'd4, 8'd250},
    {1'b0, 3'd2, 1'b0, 3'd5, 8'd2},
    {1'b0, 3'd1, 1'b1, 3'd3, 8'd0}
  };

  function automatic int exp_col(int start, int beat, int lc, bit ilv);
    int sz;
    sz = (lc == 1) ? 2 : (lc == 2) ? 4 : (lc == 3) ? 8 : 256;
    if (sz == 256) return (start + beat) % 256;
    if (ilv) return start ^ beat;
    return start - (start % sz) + (((start % sz) + beat) % sz);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_mode(input int lc, input bit ilv, input int lat, input int exp_err, input string tag);
    mode_load = 1'b1;
    mode_word = {lat[2:0], ilv, lc[2:0]};
    @(negedge clk);
    mode_load = 1'b0;
    chk({tag, " mode_err"}, int'(mode_err), exp_err);
  endtask

  // Issue a command now (just after a negedge) and check np beat pairs
  task automatic burst(input bit wr, input int lc, input bit ilv, input int lat,
                       input int st, input int np, input string tag);
    int le;
    int k;
    bit ev;
    le = wr ? 1 : lat;
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_col   = st[7:0];
    for (int c = 1; c <= le + np; c++) begin
      @(negedge clk);
      if (c == 1) cmd_valid = 1'b0;
      ev = (c >= le) && (c < le + np);
      k  = c - le;
      chk({tag, " beat valid"}, int'(wr ? wr_vld : rd_vld), int'(ev));
      chk({tag, " other side idle"}, int'(wr ? rd_vld : wr_vld), 0);
      if (ev) begin
        chk({tag, " col0"}, int'(wr ? wr_col0 : rd_col0), exp_col(st, 2*k, lc, ilv));
        chk({tag, " col1"}, int'(wr ? wr_col1 : rd_col1), exp_col(st, 2*k+1, lc, ilv));
      end
      burst_stop = (lc == 7) && (c == np);
    end
    burst_stop = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog (all requirements): got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_word = '0; cmd_valid = 1'b0;
    cmd_write = 1'b0; cmd_col = '0; burst_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk("R12 wr_vld", int'(wr_vld), 0);
    chk("R12 rd_vld", int'(rd_vld), 0);
    chk("R12 flags", int'({mode_err, start_err, rd_refused}), 0);
    @(negedge clk);
    // R12 default settings: length 4, sequential, latency 3
    burst(1'b0, 2, 1'b0, 3, 6, 2, "R12 default read");

    // Vector table: R1, R4, R5, R6, R7, R8
    for (int v = 0; v < NV; v++) begin
      bit    wr;
      int    lc, lat, st, np;
      bit    ilv;
      string tag;
      wr  = VEC[v][15];
      lc  = int'(VEC[v][14:12]);
      ilv = VEC[v][11];
      lat = int'(VEC[v][10:8]);
      st  = int'(VEC[v][7:0]);
      np  = (lc == 7) ? 5 : ((lc == 1) ? 1 : (lc == 2) ? 2 : 4);
      do_mode(lc, ilv, lat, 0, "R1");
      tag = (lc == 7) ? "R8" : (ilv ? "R5" : "R4");
      tag = {tag, wr ? "/R6" : "/R7"};
      burst(wr, lc, ilv, lat, st, np, tag);
    end

    // R2 illegal words keep length 8 sequential
    do_mode(3, 1'b0, 3, 0, "R2 setup");
    do_mode(3, 1'b0, 6, 1, "R2 bad latency");
    do_mode(4, 1'b0, 3, 1, "R2 bad length");
    burst(1'b1, 3, 1'b0, 3, 1, 4, "R2 settings kept");

    // R3 whole page + interleave coerced to sequential
    do_mode(7, 1'b1, 3, 1, "R3");
    burst(1'b1, 7, 1'b0, 3, 2, 5, "R3 sequential fallback");

    // R9 odd start in whole-page mode
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 8'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 start_err pulse", int'(start_err), 1);
    chk("R9 no write beats", int'(wr_vld), 0);
    @(negedge clk);
    chk("R9 start_err one cycle", int'(start_err), 0);
    chk("R9 still no beats", int'(wr_vld), 0);

    // R10 read during a write burst
    do_mode(3, 1'b0, 3, 0, "R10 setup");
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 8'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 rd_refused", int'(rd_refused), 1);
    chk("R10 write continues", int'(wr_vld), 1);
    chk("R10 write col0", int'(wr_col0), 4);
    @(negedge clk);
    chk("R10 refuse one cycle", int'(rd_refused), 0);
    chk("R10 last write pair", int'(wr_col1), 7);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R10 read dropped", int'(rd_vld), 0);
    end

    // R11 restart by a new command
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 8'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = 8'd16;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 restart col0", int'(wr_col0), 16);
    chk("R11 restart col1", int'(wr_col1), 17);
    repeat (4) @(negedge clk);
    chk("R11 restart length", int'(wr_vld), 0);

    // R11 burst_stop on a length-8 write
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 8'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 first pair", int'(wr_vld), 1);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R11 stopped", int'(wr_vld), 0);
    @(negedge clk);
    chk("R11 stays stopped", int'(wr_vld), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule